// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits between the host write bus of a parallel NOR flash and its program/erase controller. Each bus write arrives as a one-cycle strobe with an address, an extra byte-lane bit and a data word. The decoder recognises the multi-write command sequences guarded by two unlock writes, and sends single-cycle start requests to the controller. These requests are program, chip erase, block erase (one pulse per block selection), suspend, resume and reset. Each request carries the latched address and data of the write that completed it.

The decoder also chooses what a bus read returns. It selects the memory array, the identification view or the controller status. In the identification view it supplies the identification word itself. The decoder filters commands by context: busy, suspended, error and the shortened-program bypass mode.

Blocks are a power-of-two number of equal regions, indexed by the top address bits. One input bit per block marks it as write-protected.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset no start output is high, `rd_mode` is 0 (array), and neither identification mode nor bypass mode is active. A start output can only rise in the cycle after a write strobe, and at most one start output is high in any cycle.
- R2: The first unlock write is low data byte AA at key address A. The second is 55 at key address B. In word mode (`byte_mode`=0), A is `wr_addr[10:0]`=0x555 and B is 0x2AA. In byte mode, A additionally needs `wr_lsb`=0 and B needs `wr_lsb`=1. Address bits above bit 10 and data bits above bit 7 are never compared.
- R3: Reset is accepted as a lone write of F0, or as the two unlock writes followed by F0 at any address. It pulses `start_reset` and leaves identification mode.
- R4: The unlock writes plus 90 at key address A enter identification mode (`rd_mode`=1). In that mode `asel_data` depends on `rd_addr[1:0]`: 00 gives `MFR_ID`; 01 gives `DEV_ID`; 10 gives 1 if the block of `rd_addr` is protected and 0 otherwise; 11 gives 0.
- R5: The unlock writes plus A0 at key address A arm a program operation. The next write pulses `start_prog`, with its address on `cmd_addr`/`cmd_lsb` and its data on `cmd_data`.
- R6: The unlock writes plus 20 at key address A enter bypass mode. In bypass mode, A0 followed by any write programs. 90 followed by 00 leaves bypass mode. Any other write is discarded. A reset F0 keeps bypass mode.
- R7: The unlock writes, then 80 at key address A, then the unlock writes again lead to the final write. A final 10 at key address A pulses `start_chip_erase`. A final 30 at any address pulses `start_blk_erase` with that address.
- R8: While `ctl_busy` is high after a program or chip erase, every write is ignored. While it is high after a block erase (not suspended), only three writes act. B0 pulses `start_suspend`. F0 pulses `start_reset`. 30 pulses `start_blk_erase` with the write address, to add a block.
- R9: While `ctl_susp` is high and `ctl_busy` is low, a lone 30 pulses `start_resume`. Identification entry and program are accepted. Bypass entry and erase setup are rejected. Reset leaves identification mode without ending the suspension. A program issued during suspension does not replace the suspended erase as the operation that R8 filters on.
- R10: While `ctl_err` is high, only a reset (either form) produces a start pulse.
- R11: A program whose address lies in a protected block produces no start pulse.
- R12: A write that neither advances nor completes a sequence drops the partial sequence and leaves identification mode.
- R13: `rd_mode` is 2 (status) whenever `ctl_busy` or `ctl_err` is high. It follows these inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 = 8-bit bus, key addresses include `wr_lsb` |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Word address of the write |
| wr_lsb | input | 1 | Byte-lane address bit, used in byte mode |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address for the identification view |
| prot_mask | input | NBLK | Per-block protection bits |
| ctl_busy | input | 1 | Controller is running an operation |
| ctl_susp | input | 1 | Controller holds a suspended block erase |
| ctl_err | input | 1 | Controller reports a failed operation |
| start_prog | output | 1 | Program request pulse |
| start_chip_erase | output | 1 | Chip erase request pulse |
| start_blk_erase | output | 1 | Block erase / add-block request pulse |
| start_suspend | output | 1 | Suspend request pulse |
| start_resume | output | 1 | Resume request pulse |
| start_reset | output | 1 | Reset / abort request pulse |
| cmd_addr | output | AW | Address latched with the last program or block request |
| cmd_lsb | output | 1 | Byte-lane bit latched with it |
| cmd_data | output | DW | Data latched with it |
| rd_mode | output | 2 | Read view: 0 array, 1 identification, 2 status |
| asel_data | output | DW | Identification read data |

## Verification
The assertions check several properties on every cycle. At most one start pulse fires. Pulses follow only a write strobe. Nothing starts while a program or chip erase is busy. Only reset passes under error. A protected program never pulses, and bypass mode is entered only by a 20 write. The bench's reference model compares every output on every clock, and only its scenarios can show the full sequences. These include byte-mode key addresses and the lane bit, the identification data, bypass persistence across reset, adding blocks and suspending during block erase, and return to the suspended state after identification.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CMP_W = 11;
    localparam logic [CMP_W-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [CMP_W-1:0] KEY_ADDR_B = 11'h2AA;

    localparam logic [7:0] C_KEY1    = 8'hAA;
    localparam logic [7:0] C_KEY2    = 8'h55;
    localparam logic [7:0] C_RESET   = 8'hF0;
    localparam logic [7:0] C_IDENT   = 8'h90;
    localparam logic [7:0] C_PROG    = 8'hA0;
    localparam logic [7:0] C_BYP     = 8'h20;
    localparam logic [7:0] C_ERASE   = 8'h80;
    localparam logic [7:0] C_CHIP    = 8'h10;
    localparam logic [7:0] C_CONFIRM = 8'h30;
    localparam logic [7:0] C_SUSP    = 8'hB0;
    localparam logic [7:0] C_BYPX    = 8'h00;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_K1, SQ_K2, SQ_PADDR, SQ_E1, SQ_E2, SQ_E3, SQ_BPADDR, SQ_BEXIT
    } seq_t;

    typedef enum logic [3:0] {
        K_INV, K_PRE, K_RST, K_IDENT, K_PROG, K_BYP, K_BYPX, K_CHIP, K_BLK, K_RES
    } kind_t;

    typedef enum logic [1:0] { OP_NONE, OP_PROG, OP_CHIP, OP_BLK } op_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rdmode_t;

    typedef struct packed {
        logic prog;
        logic chip;
        logic blk;
        logic susp;
        logic resume;
        logic rst;
    } start_t;

endpackage

// File: rtl/fcs_key_match.sv
module fcs_key_match
    import fcs_pkg::*;
(
    input  logic [CMP_W-1:0] addr_lo,
    input  logic             lsb,
    input  logic             byte_mode,
    output logic             hit_a,
    output logic             hit_b
);
    // In byte mode the lane bit extends the compared address by one bit.
    always_comb begin
        hit_a = (addr_lo == KEY_ADDR_A) && (!byte_mode || !lsb);
        hit_b = (addr_lo == KEY_ADDR_B) && (!byte_mode ||  lsb);
    end
endmodule

// File: rtl/fcs_prot_lookup.sv
module fcs_prot_lookup #(
    parameter int NBLK = 8,
    localparam int BB  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic [BB-1:0]   blk_idx,
    input  logic [NBLK-1:0] mask,
    output logic            hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NBLK; i++) begin
            if (blk_idx == BB'(i)) hit = mask[i];
        end
    end
endmodule

// File: rtl/fcs_ident_rom.sv
module fcs_ident_rom #(
    parameter int          DW     = 16,
    parameter logic [15:0] MFR_ID = 16'h0011,
    parameter logic [15:0] DEV_ID = 16'h00A7
) (
    input  logic [1:0]    sel,
    input  logic          prot,
    output logic [DW-1:0] dout
);
    always_comb begin
        unique case (sel)
            2'b00:   dout = DW'(MFR_ID);
            2'b01:   dout = DW'(DEV_ID);
            2'b10:   dout = DW'(prot);
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/fcs_cmd_fsm.sv
module fcs_cmd_fsm
    import fcs_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_lsb,
    input  logic [DW-1:0] wr_data,
    input  logic          hit_a,
    input  logic          hit_b,
    input  logic          wr_prot,
    input  logic          ctl_busy,
    input  logic          ctl_susp,
    input  logic          ctl_err,
    output start_t        start,
    output logic [AW-1:0] cmd_addr,
    output logic          cmd_lsb,
    output logic [DW-1:0] cmd_data,
    output rdmode_t       rd_mode
);
    typedef struct packed {
        seq_t          seq;
        logic          byp;
        logic          ident;
        op_t           op;
        start_t        pulse;
        logic [AW-1:0] addr;
        logic          lsb;
        logic [DW-1:0] data;
    } st_t;

    st_t        st_d, st_q;
    kind_t      kind;
    seq_t       nxt;
    logic [7:0] code;
    logic       latch;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        kind       = K_INV;
        nxt        = SQ_IDLE;
        code       = wr_data[7:0];
        latch      = 1'b0;

        if (wr_en) begin
            if (ctl_busy) begin
                // Running operation: sequences restart; only block erase listens.
                st_d.seq = SQ_IDLE;
                if (st_q.op == OP_BLK && !ctl_susp) begin
                    if (code == C_RESET) begin
                        st_d.pulse.rst = 1'b1;
                        st_d.ident     = 1'b0;
                    end else if (!ctl_err && code == C_SUSP) begin
                        st_d.pulse.susp = 1'b1;
                    end else if (!ctl_err && code == C_CONFIRM) begin
                        st_d.pulse.blk = 1'b1;
                        latch          = 1'b1;
                    end
                end
            end else begin
                unique case (st_q.seq)
                    SQ_IDLE: begin
                        if (st_q.byp) begin
                            if (code == C_PROG) begin
                                kind = K_PRE; nxt = SQ_BPADDR;
                            end else if (code == C_IDENT) begin
                                kind = K_PRE; nxt = SQ_BEXIT;
                            end else if (code == C_RESET) begin
                                kind = K_RST;
                            end
                        end else begin
                            if (code == C_RESET) begin
                                kind = K_RST;
                            end else if (code == C_CONFIRM && ctl_susp) begin
                                kind = K_RES;
                            end else if (code == C_KEY1 && hit_a) begin
                                kind = K_PRE; nxt = SQ_K1;
                            end
                        end
                    end
                    SQ_K1: begin
                        if (code == C_KEY2 && hit_b) begin
                            kind = K_PRE; nxt = SQ_K2;
                        end
                    end
                    SQ_K2: begin
                        if (code == C_RESET) begin
                            kind = K_RST;
                        end else if (hit_a) begin
                            if (code == C_IDENT) begin
                                kind = K_IDENT;
                            end else if (code == C_PROG) begin
                                kind = K_PRE; nxt = SQ_PADDR;
                            end else if (code == C_BYP && !ctl_susp) begin
                                kind = K_BYP;
                            end else if (code == C_ERASE && !ctl_susp) begin
                                kind = K_PRE; nxt = SQ_E1;
                            end
                        end
                    end
                    SQ_PADDR, SQ_BPADDR: kind = K_PROG;
                    SQ_BEXIT: begin
                        if (code == C_BYPX) kind = K_BYPX;
                    end
                    SQ_E1: begin
                        if (code == C_KEY1 && hit_a) begin
                            kind = K_PRE; nxt = SQ_E2;
                        end
                    end
                    SQ_E2: begin
                        if (code == C_KEY2 && hit_b) begin
                            kind = K_PRE; nxt = SQ_E3;
                        end
                    end
                    SQ_E3: begin
                        if (code == C_CHIP && hit_a) kind = K_CHIP;
                        else if (code == C_CONFIRM)  kind = K_BLK;
                    end
                    default: kind = K_INV;
                endcase

                // Under an error only reset may complete.
                if (ctl_err && kind != K_PRE && kind != K_RST) kind = K_INV;

                st_d.seq = (kind == K_PRE) ? nxt : SQ_IDLE;

                unique case (kind)
                    K_INV:   st_d.ident = 1'b0;
                    K_PRE:   ;
                    K_RST: begin
                        st_d.pulse.rst = 1'b1;
                        st_d.ident     = 1'b0;
                    end
                    K_IDENT: st_d.ident = 1'b1;
                    K_PROG: begin
                        st_d.ident = 1'b0;
                        if (!wr_prot) begin
                            st_d.pulse.prog = 1'b1;
                            latch           = 1'b1;
                            if (!ctl_susp) st_d.op = OP_PROG;
                        end
                    end
                    K_BYP: begin
                        st_d.byp   = 1'b1;
                        st_d.ident = 1'b0;
                    end
                    K_BYPX:  st_d.byp = 1'b0;
                    K_CHIP: begin
                        st_d.pulse.chip = 1'b1;
                        st_d.op         = OP_CHIP;
                        st_d.ident      = 1'b0;
                        latch           = 1'b1;
                    end
                    K_BLK: begin
                        st_d.pulse.blk = 1'b1;
                        st_d.op        = OP_BLK;
                        st_d.ident     = 1'b0;
                        latch          = 1'b1;
                    end
                    K_RES: begin
                        st_d.pulse.resume = 1'b1;
                        st_d.ident        = 1'b0;
                    end
                    default: st_d.ident = 1'b0;
                endcase
            end
        end

        if (latch) begin
            st_d.addr = wr_addr;
            st_d.lsb  = wr_lsb;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (ctl_busy || ctl_err) rd_mode = RM_STATUS;
        else if (st_q.ident)     rd_mode = RM_IDENT;
        else                     rd_mode = RM_ARRAY;
    end

    assign start    = st_q.pulse;
    assign cmd_addr = st_q.addr;
    assign cmd_lsb  = st_q.lsb;
    assign cmd_data = st_q.data;

    // R1
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start));

    // R1
    start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (start == '0));

    // R8
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_busy && st_q.op != OP_BLK) |=> (start == '0));

    // R10
    err_reset_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err |=> !(start.prog || start.chip || start.blk || start.susp || start.resume));

    // R11
    prot_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_prot) |=> !start.prog);

    // R6
    byp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.byp) |-> ($past(wr_data[7:0]) == C_BYP));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int          AW     = 18,
    parameter int          DW     = 16,
    parameter int          NBLK   = 8,
    parameter logic [15:0] MFR_ID = 16'h0011,
    parameter logic [15:0] DEV_ID = 16'h00A7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_mode,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_lsb,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    input  logic [NBLK-1:0] prot_mask,
    input  logic            ctl_busy,
    input  logic            ctl_susp,
    input  logic            ctl_err,
    output logic            start_prog,
    output logic            start_chip_erase,
    output logic            start_blk_erase,
    output logic            start_suspend,
    output logic            start_resume,
    output logic            start_reset,
    output logic [AW-1:0]   cmd_addr,
    output logic            cmd_lsb,
    output logic [DW-1:0]   cmd_data,
    output logic [1:0]      rd_mode,
    output logic [DW-1:0]   asel_data
);
    localparam int BB = (NBLK > 1) ? $clog2(NBLK) : 1;

    logic    hit_a, hit_b, wr_prot, rd_prot;
    start_t  start;
    rdmode_t rm;

    fcs_key_match u_keys (
        .addr_lo   (wr_addr[CMP_W-1:0]),
        .lsb       (wr_lsb),
        .byte_mode (byte_mode),
        .hit_a     (hit_a),
        .hit_b     (hit_b)
    );

    fcs_prot_lookup #(.NBLK(NBLK)) u_wprot (
        .blk_idx (wr_addr[AW-1 -: BB]),
        .mask    (prot_mask),
        .hit     (wr_prot)
    );

    fcs_prot_lookup #(.NBLK(NBLK)) u_rprot (
        .blk_idx (rd_addr[AW-1 -: BB]),
        .mask    (prot_mask),
        .hit     (rd_prot)
    );

    fcs_ident_rom #(.DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rom (
        .sel  (rd_addr[1:0]),
        .prot (rd_prot),
        .dout (asel_data)
    );

    fcs_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_lsb   (wr_lsb),
        .wr_data  (wr_data),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .wr_prot  (wr_prot),
        .ctl_busy (ctl_busy),
        .ctl_susp (ctl_susp),
        .ctl_err  (ctl_err),
        .start    (start),
        .cmd_addr (cmd_addr),
        .cmd_lsb  (cmd_lsb),
        .cmd_data (cmd_data),
        .rd_mode  (rm)
    );

    assign rd_mode          = rm;
    assign start_prog       = start.prog;
    assign start_chip_erase = start.chip;
    assign start_blk_erase  = start.blk;
    assign start_suspend    = start.susp;
    assign start_resume     = start.resume;
    assign start_reset      = start.rst;

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int NBLK = 8;
    localparam logic [15:0] MFR = 16'h0011;
    localparam logic [15:0] DEV = 16'h00A7;
    // kinds of outcome in the model
    localparam int K_INV = 0, K_PRE = 1, K_RST = 2, K_IDENT = 3, K_PROG = 4,
                   K_BYP = 5, K_BYPX = 6, K_CHIP = 7, K_BLK = 8, K_RES = 9;
    // expected pulse bits {prog, chip, blk, susp, resume, rst}
    localparam logic [5:0] P_PROG = 6'b100000, P_CHIP = 6'b010000, P_BLK = 6'b001000,
                           P_SUSP = 6'b000100, P_RES = 6'b000010, P_RST = 6'b000001;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n = 1'b0, byte_mode = 1'b0, wr_en = 1'b0, wr_lsb = 1'b0;
    logic [AW-1:0]   wr_addr = '0, rd_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [NBLK-1:0] prot_mask = 8'b0000_0100;
    logic            ctl_busy = 1'b0, ctl_susp = 1'b0, ctl_err = 1'b0;
    logic            start_prog, start_chip_erase, start_blk_erase;
    logic            start_suspend, start_resume, start_reset, cmd_lsb;
    logic [AW-1:0]   cmd_addr;
    logic [DW-1:0]   cmd_data, asel_data;
    logic [1:0]      rd_mode;

    flash_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_data(wr_data), .rd_addr(rd_addr),
        .prot_mask(prot_mask), .ctl_busy(ctl_busy), .ctl_susp(ctl_susp), .ctl_err(ctl_err),
        .start_prog(start_prog), .start_chip_erase(start_chip_erase),
        .start_blk_erase(start_blk_erase), .start_suspend(start_suspend),
        .start_resume(start_resume), .start_reset(start_reset),
        .cmd_addr(cmd_addr), .cmd_lsb(cmd_lsb), .cmd_data(cmd_data),
        .rd_mode(rd_mode), .asel_data(asel_data)
    );

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit            m_byp = 0, m_ident = 0;
    int            m_op = 0; // 0 none, 1 program, 2 chip, 3 block
    logic [5:0]    e_pulse = '0;
    logic [AW-1:0] e_addr = '0;
    logic [DW-1:0] e_data = '0;
    int            hist[$];  // code | key-A hit << 8 | key-B hit << 9

    function automatic int classify();
        int n = hist.size();
        int c = hist[n-1] & 255;
        bit a5 = hist[n-1][8];
        bit a2 = hist[n-1][9];
        if (m_byp) begin
            if (n == 1) begin
                if (c == 'hA0 || c == 'h90) return K_PRE;
                return (c == 'hF0) ? K_RST : K_INV;
            end
            if ((hist[0] & 255) == 'hA0) return K_PROG;
            return (c == 0) ? K_BYPX : K_INV;
        end
        case (n)
            1: begin
                if (c == 'hF0) return K_RST;
                if (c == 'h30 && ctl_susp) return K_RES;
                return (c == 'hAA && a5) ? K_PRE : K_INV;
            end
            2: return (c == 'h55 && a2) ? K_PRE : K_INV;
            3: begin
                if (c == 'hF0) return K_RST;
                if (!a5) return K_INV;
                if (c == 'h90) return K_IDENT;
                if (c == 'hA0) return K_PRE;
                if (c == 'h20 && !ctl_susp) return K_BYP;
                if (c == 'h80 && !ctl_susp) return K_PRE;
                return K_INV;
            end
            4: begin
                if ((hist[2] & 255) == 'hA0) return K_PROG;
                return (c == 'hAA && a5) ? K_PRE : K_INV;
            end
            5: return (c == 'h55 && a2) ? K_PRE : K_INV;
            6: begin
                if (c == 'h10 && a5) return K_CHIP;
                return (c == 'h30) ? K_BLK : K_INV;
            end
            default: return K_INV;
        endcase
    endfunction

    always @(posedge clk) begin
        int code, k;
        bit h5, h2;
        e_pulse = '0;
        if (!rst_n) begin
            m_byp = 0; m_ident = 0; m_op = 0; hist.delete();
        end else if (wr_en) begin
            code = int'(wr_data[7:0]);
            h5 = (wr_addr[10:0] == 11'h555) && (!byte_mode || !wr_lsb);
            h2 = (wr_addr[10:0] == 11'h2AA) && (!byte_mode || wr_lsb);
            if (ctl_busy) begin
                hist.delete();
                if (m_op == 3 && !ctl_susp) begin
                    if (code == 'hF0) begin e_pulse = P_RST; m_ident = 0; end
                    else if (!ctl_err && code == 'hB0) e_pulse = P_SUSP;
                    else if (!ctl_err && code == 'h30) begin e_pulse = P_BLK; e_addr = wr_addr; end
                end
            end else begin
                hist.push_back(code | (int'(h5) << 8) | (int'(h2) << 9));
                k = classify();
                if (ctl_err && k != K_PRE && k != K_RST) k = K_INV;
                case (k)
                    K_INV:   m_ident = 0;
                    K_RST:   begin e_pulse = P_RST; m_ident = 0; end
                    K_IDENT: m_ident = 1;
                    K_PROG: begin
                        m_ident = 0;
                        if (!prot_mask[wr_addr[AW-1 -: 3]]) begin
                            e_pulse = P_PROG; e_addr = wr_addr; e_data = wr_data;
                            if (!ctl_susp) m_op = 1;
                        end
                    end
                    K_BYP:   begin m_byp = 1; m_ident = 0; end
                    K_BYPX:  m_byp = 0;
                    K_CHIP:  begin e_pulse = P_CHIP; m_op = 2; m_ident = 0; end
                    K_BLK:   begin e_pulse = P_BLK; e_addr = wr_addr; m_op = 3; m_ident = 0; end
                    K_RES:   begin e_pulse = P_RES; m_ident = 0; end
                    default: ;
                endcase
                if (k != K_PRE) hist.delete();
            end
        end
    end

    // compare on every clock, a quarter period after the rising edge
    always @(posedge clk) begin
        logic [1:0]    exp_rm;
        logic [DW-1:0] exp_id;
        #5;
        if (!finished) begin
            chk("start pulses", {start_prog, start_chip_erase, start_blk_erase,
                                 start_suspend, start_resume, start_reset}, e_pulse);
            if (e_pulse == P_PROG || e_pulse == P_BLK) chk("cmd_addr", cmd_addr, e_addr);
            if (e_pulse == P_PROG) chk("cmd_data", cmd_data, e_data);
            exp_rm = (ctl_busy || ctl_err) ? 2'd2 : (m_ident ? 2'd1 : 2'd0);
            chk("rd_mode", rd_mode, exp_rm);
            case (rd_addr[1:0])
                2'b00: exp_id = MFR;
                2'b01: exp_id = DEV;
                2'b10: exp_id = DW'(prot_mask[rd_addr[AW-1 -: 3]]);
                default: exp_id = '0;
            endcase
            chk("asel_data", asel_data, exp_id);
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic l, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_lsb = l; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock_w();
        wr(18'h00555, 1'b0, 16'h00AA);
        wr(18'h002AA, 1'b0, 16'h0055);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_id(input logic [AW-1:0] a, input logic [DW-1:0] exp, string what);
        @(negedge clk);
        rd_addr = a;
        #5;
        chk(what, asel_data, exp);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        cur_req = "R1"; idle(3);

        cur_req = "R4";
        unlock_w(); wr(18'h00555, 1'b0, 16'h0090); idle(1);
        chk("rd_mode ident", rd_mode, 2'd1);
        read_id(18'h00000, MFR, "manufacturer");
        read_id(18'h00001, DEV, "device");
        read_id(18'h10002, 16'h0001, "protected block");
        read_id(18'h28002, 16'h0000, "open block");
        cur_req = "R3"; wr(18'h12345, 1'b0, 16'h00F0); idle(1);
        chk("rd_mode after reset", rd_mode, 2'd0);

        cur_req = "R5";
        unlock_w(); wr(18'h00555, 1'b0, 16'h00A0); wr(18'h01234, 1'b0, 16'hBEEF);
        cur_req = "R8"; ctl_busy = 1'b1;
        unlock_w(); wr(18'h00555, 1'b0, 16'h00F0); wr(18'h0, 1'b0, 16'h00B0);
        ctl_busy = 1'b0; idle(2);

        cur_req = "R2"; byte_mode = 1'b1;
        wr(18'h00555, 1'b0, 16'h00AA); wr(18'h002AA, 1'b1, 16'h0055); wr(18'h00555, 1'b0, 16'h0090);
        cur_req = "R3";
        wr(18'h00555, 1'b0, 16'h00AA); wr(18'h002AA, 1'b1, 16'h0055); wr(18'h3FFFF, 1'b1, 16'h00F0);
        cur_req = "R2";
        wr(18'h00555, 1'b1, 16'h00AA); wr(18'h002AA, 1'b1, 16'h0055); wr(18'h00555, 1'b0, 16'h0090);
        idle(1); chk("wrong lane no ident", rd_mode, 2'd0);
        byte_mode = 1'b0;
        wr(18'h3F555, 1'b1, 16'hFFAA); wr(18'h1A2AA, 1'b0, 16'h1255);
        wr(18'h20555, 1'b0, 16'h77A0); wr(18'h02468, 1'b1, 16'h5A5A);

        cur_req = "R12";
        unlock_w(); wr(18'h00555, 1'b0, 16'h0077);
        wr(18'h00555, 1'b0, 16'h00A0); wr(18'h01111, 1'b0, 16'h1111);
        unlock_w(); wr(18'h00555, 1'b0, 16'h0090); wr(18'h00000, 1'b0, 16'h0042);
        idle(1); chk("ident cleared", rd_mode, 2'd0);

        cur_req = "R11";
        unlock_w(); wr(18'h00555, 1'b0, 16'h00A0); wr(18'h10010, 1'b0, 16'h0000);

        cur_req = "R6";
        unlock_w(); wr(18'h00555, 1'b0, 16'h0020);
        wr(18'h0, 1'b0, 16'h00A0); wr(18'h04000, 1'b0, 16'hC0DE);
        wr(18'h00555, 1'b0, 16'h0080); wr(18'h00555, 1'b0, 16'h00AA);
        wr(18'h0, 1'b0, 16'h00F0);
        wr(18'h0, 1'b0, 16'h00A0); wr(18'h04002, 1'b0, 16'h1234);
        wr(18'h0, 1'b0, 16'h0090); wr(18'h0, 1'b0, 16'h0000);
        wr(18'h0, 1'b0, 16'h00A0); wr(18'h04004, 1'b0, 16'h5678);

        cur_req = "R7";
        unlock_w(); wr(18'h00555, 1'b0, 16'h0080); unlock_w(); wr(18'h00555, 1'b0, 16'h0010);
        cur_req = "R8"; ctl_busy = 1'b1; idle(1);
        wr(18'h0, 1'b0, 16'h00B0); wr(18'h0, 1'b0, 16'h00F0);
        cur_req = "R13"; idle(1); chk("status while busy", rd_mode, 2'd2);
        ctl_busy = 1'b0; idle(1);

        cur_req = "R7";
        unlock_w(); wr(18'h00555, 1'b0, 16'h0080); unlock_w(); wr(18'h28000, 1'b0, 16'h0030);
        cur_req = "R8"; ctl_busy = 1'b1;
        wr(18'h30000, 1'b0, 16'h0030); wr(18'h0, 1'b0, 16'h0055);
        wr(18'h0, 1'b0, 16'h00B0);
        cur_req = "R9"; ctl_busy = 1'b0; ctl_susp = 1'b1;
        unlock_w(); wr(18'h00555, 1'b0, 16'h0090); idle(1);
        chk("ident in suspend", rd_mode, 2'd1);
        wr(18'h0, 1'b0, 16'h00F0); idle(1);
        chk("back to suspended read", rd_mode, 2'd0);
        unlock_w(); wr(18'h00555, 1'b0, 16'h0080); wr(18'h00555, 1'b0, 16'h00AA);
        unlock_w(); wr(18'h00555, 1'b0, 16'h0020); wr(18'h0, 1'b0, 16'h00A0);
        unlock_w(); wr(18'h00555, 1'b0, 16'h00A0); wr(18'h08000, 1'b0, 16'h00FE);
        ctl_busy = 1'b1; wr(18'h0, 1'b0, 16'h00F0); ctl_busy = 1'b0;
        wr(18'h0, 1'b0, 16'h0030);
        ctl_susp = 1'b0; ctl_busy = 1'b1;
        cur_req = "R8"; wr(18'h0, 1'b0, 16'h00F0);
        ctl_busy = 1'b0; idle(1);

        cur_req = "R10"; ctl_err = 1'b1;
        unlock_w(); wr(18'h00555, 1'b0, 16'h00A0); wr(18'h01000, 1'b0, 16'h0001);
        unlock_w(); wr(18'h00555, 1'b0, 16'h0090);
        wr(18'h0, 1'b0, 16'h0030);
        unlock_w(); wr(18'h00777, 1'b0, 16'h00F0);
        cur_req = "R13"; idle(1); chk("status on error", rd_mode, 2'd2);
        ctl_err = 1'b0; cur_req = "R10"; idle(1);
        chk("no ident after error", rd_mode, 2'd0);

        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
        chk("reset mode", rd_mode, 2'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule